// File: doc/BRIEF.md
# Serial Configuration Port with Protocol Auto-Select

This block is the device side of the serial configuration port of a synthesizer-style chip. After reset it counts a fixed settling interval (a parameter, nominally about 450 µs of system clock). It then waits for the first rising edge on the serial clock or the serial enable. Whichever line rises first fixes the protocol until the next reset. A serial-clock-first start selects the open protocol. An enable-first start selects the alternate protocol.

In the open protocol a host frames each write by holding `sen` high. During the frame it clocks 32 bits on `sdi`, MSB first. The 32 bits carry a 24-bit data word, then a 5-bit register index, then a 3-bit device tag. The device tag is wired to zero inside the block and cannot be changed. A host that drives several of these ports must therefore give each port its own enable line. When the enable drops, the block checks the frame. If it holds exactly 32 bits with a zero tag, the data word is written into one of 32 registers. In the alternate protocol frames are accepted on the lines but ignored. The inputs `sck`, `sen` and `sdi` are asynchronous. Each passes through a two-flop synchronizer before the edges are detected.

Top module: `synth_cfg_port`

## Requirements
- R1: While reset is held and when it is released, all 32 registers read zero, `mode` reads 2'b00 (undecided) and `frame_err` is 0.
- R2: During the first POR_CYCLES clocks after reset, rising edges on `sck` or `sen` are ignored and `mode` stays 2'b00.
- R3: After the wait, a rising `sck` that arrives before any rising `sen` sets `mode` to 2'b01 (open protocol).
- R4: After the wait, a rising `sen` that arrives before any rising `sck` sets `mode` to 2'b10 (alternate protocol).
- R5: In the open protocol, bits are sampled on rising `sck` while `sen` is high, MSB first. Frame bits 31..8 are the data, bits 7..3 are the register index, and bits 2..0 are the device tag. Register `i` appears on `reg_bank[i*24 +: 24]`. The write takes effect when `sen` falls.
- R6: A 32-bit frame whose device tag is not 3'b000 changes no register and leaves `frame_err` at 0.
- R7: When an open-protocol frame closes with a bit count other than 32, no register changes and `frame_err` becomes 1. When a frame closes with exactly 32 bits, `frame_err` becomes 0.
- R8: In the alternate protocol, frames leave every register unchanged and `frame_err` stays 0.
- R9: If `sck` and `sen` first rise in the same synchronized cycle, the open protocol is chosen.
- R10: Once chosen, `mode` holds through any later edges until reset. After reset a new selection is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset (power-on) |
| sck | input | 1 | Serial clock, asynchronous |
| sen | input | 1 | Serial enable, high frames a transfer, asynchronous |
| sdi | input | 1 | Serial data in, asynchronous |
| reg_bank | output | 768 | Register contents, 32 × 24 bits, register i at [i*24 +: 24] |
| mode | output | 2 | 00 undecided, 01 open, 10 alternate |
| frame_err | output | 1 | Last closed open-protocol frame had a wrong bit count |

## Verification
Directed frames aimed at registers 0 and 31 with alternating and all-ones data check the field order and the MSB-first sampling. Random frames then mix valid writes, non-zero device tags and short or long frames (31, 33 bits). This separates a genuine write from a tag rejection and from a length error, each checked against a register model. The protocol choice is tested three ways in separate power-ups: clock first, enable first, and both at once. Edges injected inside the settling interval show that they cannot decide the mode. Alternate-protocol frames show that the registers stay frozen.

// File: rtl/synth_cfg_port.sv
module synth_cfg_port #(
  parameter int DW         = 24,
  parameter int AW         = 5,
  parameter int TW         = 3,
  parameter int POR_CYCLES = 22500
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        sck,
  input  logic                        sen,
  input  logic                        sdi,
  output logic [(1<<AW)*DW-1:0]       reg_bank,
  output logic [1:0]                  mode,
  output logic                        frame_err
);
  localparam int NREGS = 1 << AW;
  localparam int FW    = DW + AW + TW;
  localparam int PW    = $clog2(POR_CYCLES + 1);
  localparam int CW    = $clog2(FW + 2);
  localparam logic [TW-1:0] DEV_TAG = '0;
  localparam logic [1:0] M_NONE = 2'b00, M_OPEN = 2'b01, M_ALT = 2'b10;

  logic [2:0] sck_q, sen_q;
  logic [1:0] sdi_q;
  logic [PW-1:0] por_cnt;
  logic [CW-1:0] bit_cnt;
  logic [FW-1:0] shreg;
  logic          in_frame;
  logic [DW-1:0] bank [NREGS];

  wire sck_rise   = sck_q[1] & ~sck_q[2];
  wire sen_rise   = sen_q[1] & ~sen_q[2];
  wire sen_fall   = sen_q[2] & ~sen_q[1];
  wire por_done   = (por_cnt == PW'(POR_CYCLES));
  wire frame_take = sen_fall & in_frame;
  wire full_len   = (bit_cnt == CW'(FW));
  wire do_write   = frame_take & full_len & (shreg[TW-1:0] == DEV_TAG);
  wire [AW-1:0] wr_idx = shreg[TW +: AW];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q <= '0;
      sen_q <= '0;
      sdi_q <= '0;
    end else begin
      sck_q <= {sck_q[1:0], sck};
      sen_q <= {sen_q[1:0], sen};
      sdi_q <= {sdi_q[0], sdi};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) por_cnt <= '0;
    else if (!por_done) por_cnt <= por_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mode <= M_NONE;
    else if (mode == M_NONE && por_done) begin
      if (sck_rise)      mode <= M_OPEN;
      else if (sen_rise) mode <= M_ALT;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      in_frame <= 1'b0;
      bit_cnt  <= '0;
      shreg    <= '0;
    end else if (mode == M_OPEN && sen_rise) begin
      in_frame <= 1'b1;
      bit_cnt  <= '0;
    end else if (frame_take) begin
      in_frame <= 1'b0;
    end else if (in_frame && sck_rise) begin
      shreg <= {shreg[FW-2:0], sdi_q[1]};
      if (bit_cnt != CW'(FW + 1)) bit_cnt <= bit_cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) frame_err <= 1'b0;
    else if (frame_take) frame_err <= ~full_len;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) bank[i] <= '0;
    end else if (do_write) begin
      bank[wr_idx] <= shreg[FW-1 -: DW];
    end

  for (genvar g = 0; g < NREGS; g++) begin : g_out
    assign reg_bank[g*DW +: DW] = bank[g];
  end
endmodule

// File: rtl/cfg_port_checker.sv
module cfg_port_checker #(
  parameter int WIDTH      = 768,
  parameter int POR_CYCLES = 22500
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode,
  input logic             frame_err,
  input logic [WIDTH-1:0] reg_bank,
  input logic             frame_take
);
  logic [31:0] since_rst;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) since_rst <= '0;
    else if (since_rst <= 32'(POR_CYCLES)) since_rst <= since_rst + 1'b1;

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mode == 2'b00 && !frame_err && reg_bank == '0));

  assert_por_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst <= 32'(POR_CYCLES)) |-> (mode == 2'b00));

  assert_mode_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b00) |=> (mode == $past(mode)));

  assert_write_on_close_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(reg_bank) |-> $past(frame_take));

  assert_err_open_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> (mode == 2'b01));

  assert_alt_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10) |=> ($stable(reg_bank) && !frame_err));
endmodule

bind synth_cfg_port cfg_port_checker #(
  .WIDTH((1 << AW) * DW),
  .POR_CYCLES(POR_CYCLES)
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .mode(mode),
  .frame_err(frame_err),
  .reg_bank(reg_bank),
  .frame_take(frame_take)
);

// File: tb/sim_synth_cfg_port.sv
module sim_synth_cfg_port;
  localparam int CLK_PERIOD = 10;
  localparam int POR = 100;
  localparam int HB  = 4;

  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, sen = 1'b0, sdi = 1'b0;
  logic [767:0] bank;
  logic [1:0]   mode;
  logic         ferr;
  logic [23:0]  model [32];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  synth_cfg_port #(.POR_CYCLES(POR)) u0 (
    .clk(clk), .rst_n(rst_n), .sck(sck), .sen(sen), .sdi(sdi),
    .reg_bank(bank), .mode(mode), .frame_err(ferr));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_bank(input string req);
    int bad_i = -1;
    for (int i = 0; i < 32; i++)
      if (bank[i*24 +: 24] !== model[i] && bad_i < 0) bad_i = i;
    n_chk++;
    if (bad_i >= 0) begin
      n_bad++;
      $display("FAIL %s: reg %0d actual %h expected %h", req, bad_i,
               bank[bad_i*24 +: 24], model[bad_i]);
    end
  endtask

  function automatic logic [31:0] mk_frame(input logic [23:0] d, input logic [4:0] a, input logic [2:0] t);
    return {d, a, t};
  endfunction

  task automatic power_up();
    rst_n = 1'b0; sck = 0; sen = 0; sdi = 0;
    for (int i = 0; i < 32; i++) model[i] = '0;
    tick(5);
    rst_n = 1'b1;
  endtask

  task automatic pulse_sck();
    sck = 1; tick(HB); sck = 0; tick(HB);
  endtask

  task automatic pulse_sen();
    sen = 1; tick(HB); sen = 0; tick(HB);
  endtask

  task automatic send(input logic [39:0] bits, input int n);
    sen = 1; tick(HB);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = bits[i]; tick(2);
      sck = 1; tick(HB);
      sck = 0; tick(2);
    end
    tick(HB);
    sen = 0; tick(8);
  endtask

  task automatic open_frame(input logic [23:0] d, input logic [4:0] a, input logic [2:0] t,
                            input int n, input string req);
    logic [39:0] b;
    b = {8'h0, mk_frame(d, a, t)};
    if (n == 33) b = {7'h0, mk_frame(d, a, t), 1'b1};
    if (n == 31) b = {9'h0, mk_frame(d, a, t) >> 1};
    send(b, n);
    if (n == 32 && t == 3'b000) model[a] = d;
    check_bank(req);
    check(req, {31'h0, ferr}, {31'h0, n != 32});
  endtask

  initial begin
    tick(190000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    // R1 reset state
    rst_n = 0;
    for (int i = 0; i < 32; i++) model[i] = '0;
    tick(3);
    check("R1 mode in reset", {30'h0, mode}, 32'h0);
    check("R1 err in reset", {31'h0, ferr}, 32'h0);
    check_bank("R1 bank in reset");
    power_up();
    tick(1);
    check("R1 mode after release", {30'h0, mode}, 32'h0);
    // R2 edges inside settling window
    tick(10);
    pulse_sen(); pulse_sck(); pulse_sen();
    tick(POR + 10);
    check("R2 mode after early edges", {30'h0, mode}, 32'h0);
    // R3 clock first
    pulse_sck();
    check("R3 open selected", {30'h0, mode}, 32'h1);
    // R5 directed frames
    open_frame(24'hA5C3F0, 5'd0, 3'd0, 32, "R5 reg0");
    open_frame(24'hFFFFFF, 5'd31, 3'd0, 32, "R5 reg31");
    open_frame(24'h800001, 5'd16, 3'd0, 32, "R5 msb/lsb");
    // R6 non-zero tag
    open_frame(24'h123456, 5'd0, 3'd4, 32, "R6 tag 100");
    open_frame(24'h654321, 5'd31, 3'd1, 32, "R6 tag 001");
    // R7 wrong lengths, then recovery
    open_frame(24'h0F0F0F, 5'd3, 3'd0, 31, "R7 short");
    open_frame(24'h0F0F0F, 5'd3, 3'd0, 33, "R7 long");
    open_frame(24'h00BEEF, 5'd3, 3'd0, 32, "R7 recover");
    // random mix
    for (int k = 0; k < 48; k++) begin
      int sel, len;
      logic [2:0] tg;
      sel = $urandom_range(0, 9);
      len = (sel == 0) ? 31 : (sel == 1) ? 33 : 32;
      tg  = (sel >= 7) ? 3'($urandom_range(1, 7)) : 3'd0;
      open_frame(24'($urandom), 5'($urandom), tg, len, "R5/R6/R7 random");
    end
    // R10 later edges don't change mode
    pulse_sen(); pulse_sck();
    check("R10 open held", {30'h0, mode}, 32'h1);

    // R4 enable first, R8 frames ignored
    power_up();
    tick(1);
    check_bank("R10 bank cleared by reset");
    check("R10 mode cleared by reset", {30'h0, mode}, 32'h0);
    tick(POR + 10);
    pulse_sen();
    check("R4 alternate selected", {30'h0, mode}, 32'h2);
    for (int k = 0; k < 6; k++) begin
      send({8'h0, mk_frame(24'($urandom), 5'($urandom), 3'd0)}, (k == 2) ? 31 : 32);
      check_bank("R8 bank frozen");
      check("R8 err low", {31'h0, ferr}, 32'h0);
    end
    pulse_sck();
    check("R10 alternate held", {30'h0, mode}, 32'h2);

    // R9 simultaneous rise
    power_up();
    tick(POR + 10);
    sck = 1; sen = 1; tick(HB);
    sck = 0; sen = 0; tick(HB + 4);
    check("R9 open on tie", {30'h0, mode}, 32'h1);
    check("R9 no error from tie", {31'h0, ferr}, 32'h0);
    open_frame(24'hC0FFEE, 5'd9, 3'd0, 32, "R9 write after tie");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule